// File: doc/BRIEF.md
# Serial GPIO Expander Scan Engine

This block widens a host's pin count by driving a daisy chain of external shift registers over four wires: serial data out, serial data in, a shift clock and a load/shift strobe. Output bits go to a chain of serial-in, parallel-out latches. Input bits come back from a chain of parallel-in, serial-out registers. Up to eight output bytes and eight input bytes are supported.

Software sets up the engine through a byte-wide register port. It writes the output bytes, sets how many output and input bytes are on each chain, and picks a shift-clock divisor and the pin polarities. It then sets the enable bit together with the continuous read mode. From that point the engine repeats a scan loop without further help. Each loop loads the input chain, shifts every bit, latches the output chain and idles for one shift period. The input bytes that software reads change only as a complete set, at the end of a full loop.

Register map (byte addresses on `reg_addr`):

| Address | Register | Access |
|---|---|---|
| 0x00 + b | output byte b | read/write |
| 0x08 + b | input byte b | read only |
| 0x28 | control | read/write |
| 0x2A | clock configuration | read/write, bits [5:0] |
| 0x2B | byte counts | read/write |

Top module: `serial_io_expander`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and `ser_out`, `shift_clk` and `load_strobe` are all low.
- R2: Output byte b is at address 0x00+b and reads back the last value written to it. Input byte b is at address 0x08+b, is read-only, and a write to it leaves its value unchanged.
- R3: The count register at 0x2B holds the output byte count in bits [7:4] and the input byte count in bits [3:0]. It reads back exactly the value written. When scanning, a count above 8 is treated as 8.
- R4: The control register at 0x28 reads back exactly the value written. Scanning runs only while bit 7 is 1 and bits [2:1] equal 2'b10 (continuous mode). With any other value there is no strobe and no shift-clock activity.
- R5: Bits [3:0] of the clock configuration register at 0x2A select the divisor D, measured in system clocks:
  - 0x0 gives D = 1024
  - 0x5 gives D = 32
  - 0x6 gives D = 16
  - 0x7 gives D = 8
  - 0xC gives D = 4
  - 0xD gives D = 3
  - 0xE gives D = 2
  - every other code gives D = 1024

  One bit lasts D cycles. The shift clock is active for the last floor(D/2) of those cycles.
- R6: Bit 4 of register 0x2A inverts the shift clock, so its idle level becomes high. Bit 5 inverts the strobe in the same way. With both bits at 0, both signals idle low and are active high.
- R7: One scan is made of four phases, in this order:
  1. The strobe is active for D cycles (load).
  2. There are L = 8*max(output count, input count) bit periods.
  3. The strobe is active for D cycles (latch).
  4. There is one D-cycle gap.

  The scan then repeats. When L is 0, the load and latch phases merge into one strobe pulse of 2D cycles. The shift clock is never active while the strobe is active.
- R8: Bit period i (counted from 0) sends flat output bit L-1-i, where flat bit 8*b+k is bit k of output byte b. A flat index at or above 8 times the output count sends 0. As a result, leading zeros come first, then output byte N-1 down to byte 0, each MSB first. `ser_out` stays stable across the whole bit period.
- R9: `ser_in` is sampled at the end of the first cycle of each bit period. Sample i goes to input byte i/8, bit 7-(i%8). Samples at or beyond 8 times the input count are discarded, so those bytes keep their previous values.
- R10: All input bytes update together, at the last cycle of the latch phase. At no other time do they change.
- R11: When enable is cleared, the scan is abandoned. By the second clock edge after the write, `shift_clk` and `load_strobe` are at their idle levels. The input bytes keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| ser_out | output | 1 | Serial data to the output latch chain |
| ser_in | input | 1 | Serial data from the input load chain |
| shift_clk | output | 1 | Shift clock to both chains |
| load_strobe | output | 1 | Load/shift strobe to both chains |

## Verification
The scan is exercised with several byte-count pairs:
- More input bytes than output bytes: this exposes the padding order of the leading zeros.
- More output bytes than input bytes: this shows that extra samples are dropped while the upper input bytes are preserved.
- Counts above eight: these show clamping across the full 64-bit chains.
- Both counts zero: this gives the merged strobe pulse.

These patterns are repeated across divisors 2, 3, 4, 8, 1024 and an undefined code. They are run with both polarities, which separates off-by-one errors in the phase counter from errors in the even and odd duty split. A non-continuous mode code and a disable in the middle of a shift, under a changed input pattern, show that partially shifted data never reaches the readable input bytes.

// File: rtl/sxp_pkg.sv
// Shared constants, types and the divisor decode for the serial expander.
// Assumes a 6-bit byte address space and a fixed 4-bit divisor code.
package sxp_pkg;

    localparam int ADDR_W = 6;
    localparam int DIV_W  = 11;
    localparam int IN_BASE = 8;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 6'h28;
    localparam logic [ADDR_W-1:0] ADDR_CFG   = 6'h2A;
    localparam logic [ADDR_W-1:0] ADDR_PORTS = 6'h2B;

    localparam logic [1:0] MODE_CONTINUOUS = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_LATCH,
        ST_GAP
    } scan_st_t;

    // Map a divisor select code to the number of system clocks per bit.
    function automatic logic [DIV_W-1:0] div_of(input logic [3:0] code);
        case (code)
            4'h5:    div_of = 11'd32;
            4'h6:    div_of = 11'd16;
            4'h7:    div_of = 11'd8;
            4'hC:    div_of = 11'd4;
            4'hD:    div_of = 11'd3;
            4'hE:    div_of = 11'd2;
            default: div_of = 11'd1024;
        endcase
    endfunction

endpackage

// File: rtl/sxp_regs.sv
// Register file of the serial expander: output bytes, input bytes,
// control, clock configuration and byte counts. Reads are combinational.
// Assumes BANKS <= 8 so the input bytes fit below address 0x10.
module sxp_regs
    import sxp_pkg::*;
#(
    parameter int BANKS = 8,
    localparam int NB = 8 * BANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              commit,
    input  logic [NB-1:0]     in_new,
    output logic [NB-1:0]     out_bits,
    output logic [NB-1:0]     in_bits,
    output logic              en,
    output logic [3:0]        div_code,
    output logic              clk_inv,
    output logic              strobe_inv,
    output logic [3:0]        out_cnt,
    output logic [3:0]        in_cnt
);

    logic [7:0] ctrl_r;
    logic [5:0] cfg_r;
    logic [7:0] ports_r;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [7:0] ob;
        logic [7:0] ib;

        // Output byte b: written by software only.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ob <= '0;
            else if (we && addr == ADDR_W'(b))
                ob <= wdata;
        end

        // Input byte b: written only by a completed scan.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ib <= '0;
            else if (commit)
                ib <= in_new[8*b +: 8];
        end

        assign out_bits[8*b +: 8] = ob;
        assign in_bits[8*b +: 8]  = ib;
    end

    // Control, clock configuration and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_r  <= '0;
            cfg_r   <= '0;
            ports_r <= '0;
        end else if (we) begin
            if (addr == ADDR_CTRL)  ctrl_r  <= wdata;
            if (addr == ADDR_CFG)   cfg_r   <= wdata[5:0];
            if (addr == ADDR_PORTS) ports_r <= wdata;
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (addr == ADDR_W'(b))           rdata = out_bits[8*b +: 8];
            if (addr == ADDR_W'(IN_BASE + b)) rdata = in_bits[8*b +: 8];
        end
        case (addr)
            ADDR_CTRL:  rdata = ctrl_r;
            ADDR_CFG:   rdata = {2'b00, cfg_r};
            ADDR_PORTS: rdata = ports_r;
            default:    ;
        endcase
    end

    assign en         = ctrl_r[7] && (ctrl_r[2:1] == MODE_CONTINUOUS);
    assign div_code   = cfg_r[3:0];
    assign clk_inv    = cfg_r[4];
    assign strobe_inv = cfg_r[5];
    assign out_cnt    = ports_r[7:4];
    assign in_cnt     = ports_r[3:0];

    p_in_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(in_bits));

    p_ports_rb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_PORTS) |=> (ports_r == $past(wdata)));

endmodule

// File: rtl/sxp_phase.sv
// Bit-period timer: counts 0..div-1 while run is high and reports the
// first and last cycle and whether the shift clock is in its active part.
// Assumes div >= 2 while run is high.
module sxp_phase
    import sxp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             first,
    output logic             last,
    output logic             hi
);

    logic [DIV_W-1:0] cnt;

    // Free-running period counter, held at zero while not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt == div - 1'b1)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign first = (cnt == '0);
    assign last  = (cnt == div - 1'b1);
    assign hi    = (cnt >= div - (div >> 1));

    p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < div));

endmodule

// File: rtl/sxp_scan.sv
// Scan sequencer: load strobe, bit shifting, latch strobe, gap, repeat.
// Configuration and output data are captured at the start of each scan.
// Input samples collect in a private copy that is committed at latch end.
module sxp_scan
    import sxp_pkg::*;
#(
    parameter int BANKS = 8,
    localparam int NB = 8 * BANKS,
    localparam int IW = $clog2(NB + 1),
    localparam int XW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [3:0]    div_code,
    input  logic [3:0]    out_cnt,
    input  logic [3:0]    in_cnt,
    input  logic          clk_inv,
    input  logic          strobe_inv,
    input  logic [NB-1:0] out_bits,
    input  logic [NB-1:0] in_cur,
    input  logic          ser_in,
    output logic          ser_out,
    output logic          shift_clk,
    output logic          load_strobe,
    output logic          commit,
    output logic [NB-1:0] in_bits
);

    scan_st_t         state;
    logic [DIV_W-1:0] div_q;
    logic [IW-1:0]    len_q, nout_q, nin_q, bit_q;
    logic [NB-1:0]    out_q, in_q;
    logic             first, last, hi, take;
    logic [3:0]       oc_c, ic_c, mx;
    logic [IW-1:0]    idx;

    sxp_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != ST_IDLE),
        .div   (div_q),
        .first (first),
        .last  (last),
        .hi    (hi)
    );

    // Clamp the byte counts and form the scan length.
    always_comb begin
        oc_c = (out_cnt > 4'(BANKS)) ? 4'(BANKS) : out_cnt;
        ic_c = (in_cnt  > 4'(BANKS)) ? 4'(BANKS) : in_cnt;
        mx   = (oc_c > ic_c) ? oc_c : ic_c;
        take = en && ((state == ST_IDLE) || (state == ST_GAP && last));
    end

    // Phase sequencing; clearing enable abandons the scan at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            bit_q <= '0;
        end else if (!en) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  state <= ST_LOAD;
                ST_LOAD:  if (last) begin
                              state <= (len_q == '0) ? ST_LATCH : ST_SHIFT;
                              bit_q <= '0;
                          end
                ST_SHIFT: if (last) begin
                              if (bit_q == len_q - 1'b1) state <= ST_LATCH;
                              else                       bit_q <= bit_q + 1'b1;
                          end
                ST_LATCH: if (last) state <= ST_GAP;
                ST_GAP:   if (last) state <= ST_LOAD;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Per-scan snapshot and input sample collection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= 11'd1024;
            len_q  <= '0;
            nout_q <= '0;
            nin_q  <= '0;
            out_q  <= '0;
            in_q   <= '0;
        end else if (take) begin
            div_q  <= div_of(div_code);
            len_q  <= IW'({mx, 3'b000});
            nout_q <= IW'({oc_c, 3'b000});
            nin_q  <= IW'({ic_c, 3'b000});
            out_q  <= out_bits;
            in_q   <= in_cur;
        end else if (state == ST_SHIFT && first && bit_q < nin_q) begin
            in_q[bit_q[XW-1:0] ^ XW'(7)] <= ser_in;
        end
    end

    assign idx         = len_q - 1'b1 - bit_q;
    assign ser_out     = (state == ST_SHIFT) && (idx < nout_q) && out_q[idx[XW-1:0]];
    assign shift_clk   = clk_inv ^ (state == ST_SHIFT && hi);
    assign load_strobe = strobe_inv ^ (state == ST_LOAD || state == ST_LATCH);
    assign commit      = en && state == ST_LATCH && last;
    assign in_bits     = in_q;

    p_off_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_IDLE));

    p_bit_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (bit_q < len_q));

    p_shift_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (len_q != '0));

    p_commit_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state == ST_GAP || state == ST_IDLE));

endmodule

// File: rtl/serial_io_expander.sv
// Top level of the serial GPIO expander: register file plus scan sequencer.
// Assumes a single clock domain; the external chains are clocked by shift_clk.
module serial_io_expander
    import sxp_pkg::*;
#(
    parameter int BANKS = 8,
    localparam int NB = 8 * BANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              ser_out,
    input  logic              ser_in,
    output logic              shift_clk,
    output logic              load_strobe
);

    logic          en, clk_inv, strobe_inv, commit;
    logic [3:0]    div_code, out_cnt, in_cnt;
    logic [NB-1:0] out_bits, in_bits, in_new;

    sxp_regs #(.BANKS(BANKS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .commit     (commit),
        .in_new     (in_new),
        .out_bits   (out_bits),
        .in_bits    (in_bits),
        .en         (en),
        .div_code   (div_code),
        .clk_inv    (clk_inv),
        .strobe_inv (strobe_inv),
        .out_cnt    (out_cnt),
        .in_cnt     (in_cnt)
    );

    sxp_scan #(.BANKS(BANKS)) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .div_code    (div_code),
        .out_cnt     (out_cnt),
        .in_cnt      (in_cnt),
        .clk_inv     (clk_inv),
        .strobe_inv  (strobe_inv),
        .out_bits    (out_bits),
        .in_cur      (in_bits),
        .ser_in      (ser_in),
        .ser_out     (ser_out),
        .shift_clk   (shift_clk),
        .load_strobe (load_strobe),
        .commit      (commit),
        .in_bits     (in_new)
    );

endmodule

// File: tb/serial_io_expander_bench.sv
// Scoreboard bench: a driver task queues expected serial-out bits, and a
// monitor pops them at each active shift edge while playing the input chain.
module serial_io_expander_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       ser_in = 1'b0;
    wire  [7:0] reg_rdata;
    wire        ser_out, shift_clk, load_strobe;

    always #10 clk = ~clk;

    serial_io_expander u_serial_io_expander (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .ser_out     (ser_out),
        .ser_in      (ser_in),
        .shift_clk   (shift_clk),
        .load_strobe (load_strobe)
    );

    int          n_checks = 0, n_fail = 0, cyc = 0;
    bit          exp_q[$];
    logic [63:0] pat = '0, out_model = '0, in_model = '0;
    bit          mon_on = 0, b_ci = 0, b_si = 0, done = 0;
    int          exp_d = 2, exp_sw = 2;
    int          k = 0, last_edge = 0, hi_cnt = 0, st_cnt = 0, st_rises = 0;
    bit          prev_sc_raw = 0, prev_st_raw = 0;

    localparam logic [63:0] PAT_A = 64'h3C96_A5E1_5A0F_C387;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Monitor: plays the input chain and scores the serial output.
    always @(negedge clk) begin
        bit sc, st, psc, pst, e;
        cyc++;
        sc  = shift_clk ^ b_ci;
        st  = load_strobe ^ b_si;
        psc = prev_sc_raw ^ b_ci;
        pst = prev_st_raw ^ b_si;
        if (mon_on) begin
            if (st && !pst) begin
                k = 0; ser_in = pat[0]; st_rises++; st_cnt = 0;
            end
            if (st) st_cnt++;
            if (!st && pst)
                check(st_cnt == exp_sw, "R7 strobe width", st_cnt, exp_sw);
            if (sc && !psc) begin
                if (exp_q.size() == 0) begin
                    check(0, "R7 unexpected shift edge", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(ser_out == e, "R8 serial out bit", ser_out, e);
                end
                if (k > 0)
                    check(cyc - last_edge == exp_d, "R5 shift period", cyc - last_edge, exp_d);
                last_edge = cyc; k++;
                ser_in = (k < 64) ? pat[k] : 1'b0;
                hi_cnt = 0;
            end
            if (sc) hi_cnt++;
            if (!sc && psc)
                check(hi_cnt == exp_d / 2, "R5 high phase", hi_cnt, exp_d / 2);
        end
        prev_sc_raw = shift_clk;
        prev_st_raw = load_strobe;
        if (cyc > 190000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Driver: configure, queue expected bits, run nscan scans, stop in the gap.
    task automatic run_scan(input logic [3:0] code, input int d, input int oc, input int ic,
                            input bit ci, input bit si, input int nscan, input logic [63:0] p);
        int occ, icc, len;
        logic [7:0] v;
        occ = (oc > 8) ? 8 : oc;
        icc = (ic > 8) ? 8 : ic;
        len = 8 * ((occ > icc) ? occ : icc);
        mon_on = 0;
        wr(6'h2A, {2'b00, si, ci, code});
        b_ci = ci; b_si = si;
        wr(6'h2B, {4'(oc), 4'(ic)});
        repeat (2) @(negedge clk);
        pat = p; exp_d = d; exp_sw = (len == 0) ? 2 * d : d;
        for (int s = 0; s < nscan; s++)
            for (int i = 0; i < len; i++)
                exp_q.push_back((len - 1 - i < 8 * occ) ? out_model[len - 1 - i] : 1'b0);
        mon_on = 1;
        wr(6'h28, 8'h84);
        while (exp_q.size() != 0) @(negedge clk);
        while (!(load_strobe ^ si)) @(negedge clk);
        while (load_strobe ^ si) @(negedge clk);
        wr(6'h28, 8'h00);
        mon_on = 0;
        for (int b = 0; b < icc; b++)
            for (int j = 0; j < 8; j++)
                in_model[8*b + 7 - j] = p[8*b + j];
        @(negedge clk);
        check(shift_clk == ci, "R6 idle shift clock level", shift_clk, ci);
        check(load_strobe == si, "R6 idle strobe level", load_strobe, si);
        for (int b = 0; b < 8; b++) begin
            rd(6'(8 + b), v);
            check(v == in_model[8*b +: 8], "R9 R10 input byte after scan", v, in_model[8*b +: 8]);
        end
    endtask

    initial begin
        logic [7:0] v;
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(6'h28, v); check(v == 8'h00, "R1 control after reset", v, 0);
        rd(6'h2A, v); check(v == 8'h00, "R1 clock cfg after reset", v, 0);
        rd(6'h2B, v); check(v == 8'h00, "R1 counts after reset", v, 0);
        rd(6'h03, v); check(v == 8'h00, "R1 output byte after reset", v, 0);
        rd(6'h0B, v); check(v == 8'h00, "R1 input byte after reset", v, 0);
        check({ser_out, shift_clk, load_strobe} == 3'b000, "R1 pins after reset",
              {ser_out, shift_clk, load_strobe}, 0);

        // R2: output bytes read back; input bytes ignore writes
        for (int b = 0; b < 8; b++) begin
            v = 8'(8'h5B ^ (b * 37));
            out_model[8*b +: 8] = v;
            wr(6'(b), v);
        end
        for (int b = 0; b < 8; b++) begin
            rd(6'(b), v);
            check(v == out_model[8*b +: 8], "R2 output byte readback", v, out_model[8*b +: 8]);
        end
        wr(6'h08, 8'hFF);
        rd(6'h08, v); check(v == 8'h00, "R2 input byte write ignored", v, 0);

        // R3: count register readback, including values above 8
        wr(6'h2B, 8'h9A);
        rd(6'h2B, v); check(v == 8'h9A, "R3 count readback", v, 8'h9A);

        // R4: non-continuous mode and missing enable produce no activity
        b_ci = 0; b_si = 0; st_rises = 0; mon_on = 1;
        wr(6'h28, 8'h82);
        rd(6'h28, v); check(v == 8'h82, "R4 control readback", v, 8'h82);
        repeat (200) @(negedge clk);
        wr(6'h28, 8'h04);
        repeat (200) @(negedge clk);
        check(st_rises == 0, "R4 no strobe without continuous enable", st_rises, 0);
        mon_on = 0;
        wr(6'h28, 8'h00);

        // R8 R9: more input than output bytes, divisor 8
        run_scan(4'h7, 8, 2, 3, 0, 0, 2, PAT_A);

        // R10 R11: new pattern, abandon mid-shift
        pat = ~PAT_A;
        wr(6'h28, 8'h84);
        seen = 0;
        begin
            bit prev = 0;
            while (seen < 5) begin
                @(negedge clk);
                if (shift_clk && !prev) seen++;
                prev = shift_clk;
            end
        end
        rd(6'h08, v); check(v == in_model[7:0], "R10 input byte stable mid-scan", v, in_model[7:0]);
        wr(6'h28, 8'h00);
        @(negedge clk);
        check(shift_clk == 1'b0, "R11 shift clock idle after disable", shift_clk, 0);
        check(load_strobe == 1'b0, "R11 strobe idle after disable", load_strobe, 0);
        repeat (40) @(negedge clk);
        for (int b = 0; b < 3; b++) begin
            rd(6'(8 + b), v);
            check(v == in_model[8*b +: 8], "R11 input byte kept after abort", v, in_model[8*b +: 8]);
        end

        // R6: both polarities inverted, odd divisor
        run_scan(4'hD, 3, 1, 1, 1, 1, 2, 64'h0123_4567_89AB_CDEF);
        // R9: more output than input bytes, extra samples dropped
        run_scan(4'hE, 2, 3, 1, 0, 1, 2, 64'hF0E1_D2C3_B4A5_9687);
        // R3: counts above 8 clamp to full 64-bit chains
        run_scan(4'hC, 4, 9, 10, 1, 0, 2, 64'hDEAD_BEEF_0F1E_2D3C);
        // R5: slowest divisor
        run_scan(4'h0, 1024, 1, 0, 0, 0, 1, PAT_A);
        // R5 R7: undefined code and zero counts give a merged strobe
        run_scan(4'h3, 1024, 0, 0, 0, 0, 1, PAT_A);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule